// File: doc/BRIEF.md
# UART Host Register and Command Controller

This block is the processor-facing side of a UART. It decodes a 64-byte register window on a simple byte-wide bus with one-cycle write and read strobes. It holds two mode bytes that share one address, a derived status byte, and an interrupt status and mask pair. It also returns two fixed baud-generator bytes. The block drives one level-sensitive interrupt line.

Software controls the channel by writing a packed command byte. One write can carry a miscellaneous action, a transmitter action and a receiver action, and all three take effect together.

On the transmit side, a one-byte holding register feeds a valid/ready output stream. On the receive side, a valid/ready input stream and a break-event strobe fill a small receive queue. Software drains that queue by reading the data register. Serial bit timing, parity and break generation are left to the serial engine that sits on these two streams.

Top module: `sio_regctl`

## Requirements
- R1: After reset, the status byte (offset 0x04) reads 0x08, both mode bytes and the interrupt status read 0x00, and irq, tx_valid and rx_ready are low.
- R2: A write at offset 0x00 stores into the mode byte selected by the pointer and then points the pointer at the second mode byte. A read at 0x00 returns the selected byte. Misc command 1 points the pointer back at the first mode byte.
- R3: Writes to offset 0x04 change nothing. Offset 0x10 and every unlisted offset read 0x00. Offsets 0x18 and 0x1C read the parameters BAUD_HI and BAUD_LO.
- R4: The command byte at offset 0x08 holds the misc code in bits [6:4], the transmitter code in bits [3:2] and the receiver code in bits [1:0], and all three are applied in the same write. Misc actions are applied first. A transmitter or receiver code of 1 enables, 2 disables, and 3 changes nothing.
- R5: Misc code 2 disables the receiver and empties the receive queue, which clears status bits 0 and 1.
- R6: Misc code 3 disables the transmitter and sets TX-empty (status bit 3) while clearing TX-ready (status bit 2). Misc code 5 clears the break-change flag. Codes 0, 4, 6 and 7 have no effect.
- R7: A write of the data register (offset 0x0C) latches the byte and clears TX-empty. tx_valid equals (transmitter enabled AND NOT TX-empty), and tx_data holds the byte while it is offered. A tx_valid/tx_ready handshake sets TX-empty. Status bit 2 equals the transmitter enable.
- R8: rx_ready is high only while the receiver is enabled and the queue is not full. Accepted bytes are read back at offset 0x0C in arrival order, one byte per read, and a read of an empty queue returns 0x00. Status bit 0 means the queue is not empty, and status bit 1 means it holds DEPTH bytes.
- R9: An rx_break pulse queues a 0x00 byte whether or not the receiver is enabled, overwriting the newest entry if the queue is full, and it sets interrupt status bit 2.
- R10: Interrupt status bit 0 equals TX-ready. Bit 1 equals status bit 1 when mode byte 1 bit 6 is set, and status bit 0 otherwise. Bit 2 is the break-change flag. Bits 3 to 7 read 0.
- R11: irq is high exactly when the interrupt status ANDed with the mask (written at offset 0x14) is nonzero, with no added cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe; a read at 0x0C pops the queue |
| addr | input | 6 | Byte offset within the register window |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Bus read data, combinational from addr |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a received byte |
| rx_break | input | 1 | Break event strobe from the line |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Serial engine accepts the transmit byte |
| irq | output | 1 | Interrupt request |

## Verification
The checker watches the stream-side rules on every cycle. These are: a full queue never raises rx_ready, the queue never exceeds its depth, an offered transmit byte stays stable until it is taken, a handshake withdraws the offer, and a zero mask silences irq. It also confirms on every cycle that a queue flush, a transmitter reset and a break strobe each have their effect on the following cycle. The bench scenarios are the only place that shows the byte values themselves. That covers the mode pointer sequence, read ordering from the queue, the break byte overwriting the newest entry, the mode-selected receive interrupt source, and command writes whose fields combine.

// File: rtl/sio_pkg.sv
package sio_pkg;

  localparam int unsigned ADDR_W = 6;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFF_MODE  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_STAT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_CMD   = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_DATA  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFF_AUX   = 6'h10;
  localparam logic [ADDR_W-1:0] OFF_INT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFF_BAUDH = 6'h18;
  localparam logic [ADDR_W-1:0] OFF_BAUDL = 6'h1C;

  // mode byte 1 bit that picks the receive interrupt source
  localparam int unsigned MODE_RXSRC_BIT = 6;

  typedef enum logic [2:0] {
    MISC_NOP     = 3'd0,
    MISC_PTR_RST = 3'd1,
    MISC_RX_RST  = 3'd2,
    MISC_TX_RST  = 3'd3,
    MISC_ERR_RST = 3'd4,
    MISC_BRK_CLR = 3'd5,
    MISC_BRK_ON  = 3'd6,
    MISC_BRK_OFF = 3'd7
  } misc_e;

  typedef enum logic [1:0] {
    DIR_NOP  = 2'd0,
    DIR_ON   = 2'd1,
    DIR_OFF  = 2'd2,
    DIR_RSVD = 2'd3
  } dir_e;

  typedef struct packed {
    logic ptr_rst;
    logic rx_flush;
    logic tx_reset;
    logic brk_clr;
    logic tx_on;
    logic tx_off;
    logic rx_on;
    logic rx_off;
  } cmd_act_t;

endpackage

// File: rtl/sio_cmd_dec.sv
module sio_cmd_dec
  import sio_pkg::*;
(
  input  logic              cmd_vld,
  input  logic [BYTE_W-1:0] cmd,
  output cmd_act_t          act
);

  misc_e misc_code;
  dir_e  tx_code;
  dir_e  rx_code;

  always_comb begin
    misc_code = misc_e'(cmd[6:4]);
    tx_code   = dir_e'(cmd[3:2]);
    rx_code   = dir_e'(cmd[1:0]);
  end

  always_comb begin
    act = '0;
    if (cmd_vld) begin
      unique case (misc_code)
        MISC_PTR_RST: act.ptr_rst  = 1'b1;
        MISC_RX_RST:  act.rx_flush = 1'b1;
        MISC_TX_RST:  act.tx_reset = 1'b1;
        MISC_BRK_CLR: act.brk_clr  = 1'b1;
        default:      ;
      endcase
      act.tx_on  = (tx_code == DIR_ON);
      act.tx_off = (tx_code == DIR_OFF);
      act.rx_on  = (rx_code == DIR_ON);
      act.rx_off = (rx_code == DIR_OFF);
    end
  end

endmodule

// File: rtl/sio_rxq.sv
module sio_rxq #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             pop,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  output logic [DW-1:0]    head,
  output logic [CNT_W-1:0] count,
  output logic             not_empty,
  output logic             full
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DW-1:0]    mem_n [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] cnt_pop;
  logic [CNT_W-1:0] slot;
  logic             do_pop;

  always_comb begin
    do_pop  = pop && (cnt_q != '0);
    cnt_pop = cnt_q - CNT_W'(do_pop);
    slot    = (cnt_pop == CNT_MAX) ? CNT_MAX - 1'b1 : cnt_pop;
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem_q[i];
    if (do_pop) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
    end
    cnt_n = cnt_pop;
    if (push) begin
      mem_n[slot] = push_data;
      cnt_n       = slot + 1'b1;
    end
    if (flush) cnt_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  // storage has no reset; it is only read while the count is nonzero
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
  end

  assign head      = mem_q[0];
  assign count     = cnt_q;
  assign not_empty = (cnt_q != '0);
  assign full      = (cnt_q == CNT_MAX);

endmodule

// File: rtl/sio_txhold.sv
module sio_txhold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tx_reset,
  input  logic          tx_on,
  input  logic          tx_off,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          tx_en,
  output logic          tx_empty
);

  logic          en_q, en_n;
  logic          empty_q, empty_n;
  logic [DW-1:0] data_q;
  logic          sent;

  always_comb begin
    sent = en_q && !empty_q && out_ready;
    en_n = en_q;
    if (tx_reset) en_n = 1'b0;
    if (tx_on)    en_n = 1'b1;
    if (tx_off)   en_n = 1'b0;
    empty_n = empty_q;
    if (sent || tx_reset) empty_n = 1'b1;
    if (load)             empty_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      en_q    <= en_n;
      empty_q <= empty_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load) data_q <= load_data;
  end

  assign out_valid = en_q && !empty_q;
  assign out_data  = data_q;
  assign tx_en     = en_q;
  assign tx_empty  = empty_q;

endmodule

// File: rtl/sio_regctl.sv
module sio_regctl
  import sio_pkg::*;
#(
  parameter int unsigned    DEPTH   = 4,
  parameter logic [7:0]     BAUD_HI = 8'h05,
  parameter logic [7:0]     BAUD_LO = 8'hA0,
  localparam int unsigned   CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [5:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  input  logic        rx_break,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        irq
);

  cmd_act_t         act;
  logic             wr_mode, wr_cmd, wr_data, wr_mask, rd_pop;
  logic [7:0]       mode_q [2];
  logic [7:0]       mode_n [2];
  logic             ptr_q, ptr_n;
  logic             rx_en_q, rx_en_n;
  logic             brk_q, brk_n;
  logic [7:0]       imr_q, imr_n;
  logic             q_push;
  logic [7:0]       q_push_data;
  logic [7:0]       q_head;
  logic [CNT_W-1:0] q_count;
  logic             q_not_empty, q_full;
  logic             tx_en, tx_empty;
  logic             rx_src;
  logic [7:0]       stat_byte, isr_byte;

  always_comb begin
    wr_mode = wr_en && (addr == OFF_MODE);
    wr_cmd  = wr_en && (addr == OFF_CMD);
    wr_data = wr_en && (addr == OFF_DATA);
    wr_mask = wr_en && (addr == OFF_INT);
    rd_pop  = rd_en && (addr == OFF_DATA);
  end

  sio_cmd_dec u_dec (
    .cmd_vld (wr_cmd),
    .cmd     (wdata),
    .act     (act)
  );

  // receive path: break strobe overrides stream data
  always_comb begin
    rx_ready    = rx_en_q && !q_full && !rx_break;
    q_push      = rx_break || (rx_valid && rx_ready);
    q_push_data = rx_break ? 8'h00 : rx_data;
  end

  sio_rxq #(.DW(8), .DEPTH(DEPTH)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (act.rx_flush),
    .pop       (rd_pop),
    .push      (q_push),
    .push_data (q_push_data),
    .head      (q_head),
    .count     (q_count),
    .not_empty (q_not_empty),
    .full      (q_full)
  );

  sio_txhold #(.DW(8)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wr_data),
    .load_data (wdata),
    .tx_reset  (act.tx_reset),
    .tx_on     (act.tx_on),
    .tx_off    (act.tx_off),
    .out_ready (tx_ready),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .tx_en     (tx_en),
    .tx_empty  (tx_empty)
  );

  // next state of control registers
  always_comb begin
    mode_n[0] = mode_q[0];
    mode_n[1] = mode_q[1];
    if (wr_mode) mode_n[ptr_q] = wdata;
    ptr_n = ptr_q;
    if (wr_mode)     ptr_n = 1'b1;
    if (act.ptr_rst) ptr_n = 1'b0;
    rx_en_n = rx_en_q;
    if (act.rx_flush) rx_en_n = 1'b0;
    if (act.rx_on)    rx_en_n = 1'b1;
    if (act.rx_off)   rx_en_n = 1'b0;
    brk_n = brk_q;
    if (act.brk_clr) brk_n = 1'b0;
    if (rx_break)    brk_n = 1'b1;
    imr_n = wr_mask ? wdata : imr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q[0] <= '0;
      mode_q[1] <= '0;
      ptr_q     <= 1'b0;
      rx_en_q   <= 1'b0;
      brk_q     <= 1'b0;
      imr_q     <= '0;
    end else begin
      mode_q[0] <= mode_n[0];
      mode_q[1] <= mode_n[1];
      ptr_q     <= ptr_n;
      rx_en_q   <= rx_en_n;
      brk_q     <= brk_n;
      imr_q     <= imr_n;
    end
  end

  always_comb begin
    stat_byte = {4'b0000, tx_empty, tx_en, q_full, q_not_empty};
    rx_src    = mode_q[0][MODE_RXSRC_BIT] ? q_full : q_not_empty;
    isr_byte  = {5'b00000, brk_q, rx_src, tx_en};
    irq       = |(isr_byte & imr_q);
  end

  always_comb begin
    unique case (addr)
      OFF_MODE:  rdata = mode_q[ptr_q];
      OFF_STAT:  rdata = stat_byte;
      OFF_DATA:  rdata = q_not_empty ? q_head : 8'h00;
      OFF_INT:   rdata = isr_byte;
      OFF_BAUDH: rdata = BAUD_HI;
      OFF_BAUDL: rdata = BAUD_LO;
      default:   rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/sio_regctl_chk.sv
module sio_regctl_chk #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [5:0]       addr,
  input logic [7:0]       wdata,
  input logic             rx_ready,
  input logic             rx_break,
  input logic             tx_valid,
  input logic [7:0]       tx_data,
  input logic             tx_ready,
  input logic             irq,
  input logic [CNT_W-1:0] rx_count,
  input logic [7:0]       imr
);

  logic cmd_wr;
  assign cmd_wr = wr_en && (addr == 6'h08);

  p_full_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count == CNT_W'(DEPTH)) |-> !rx_ready);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(DEPTH));

  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !wr_en) |=> (tx_valid && $stable(tx_data)));

  p_sent_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && !wr_en) |=> !tx_valid);

  p_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[6:4] == 3'd2) |=> (rx_count == '0));

  p_tx_reset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && wdata[6:4] == 3'd3 && wdata[3:2] != 2'd1) |=> !tx_valid);

  p_break_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_break && !(cmd_wr && wdata[6:4] == 3'd2)) |=> (rx_count != '0));

  p_mask_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (imr == 8'h00) |-> !irq);

endmodule

bind sio_regctl sio_regctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .addr     (addr),
  .wdata    (wdata),
  .rx_ready (rx_ready),
  .rx_break (rx_break),
  .tx_valid (tx_valid),
  .tx_data  (tx_data),
  .tx_ready (tx_ready),
  .irq      (irq),
  .rx_count (q_count),
  .imr      (imr_q)
);

// File: tb/sio_regctl_bench.sv
module sio_regctl_bench;

  localparam logic [7:0] BH = 8'h05;
  localparam logic [7:0] BL = 8'hA0;

  logic       clk, rst_n, wr_en, rd_en;
  logic [5:0] addr;
  logic [7:0] wdata, rdata, rx_data, tx_data;
  logic       rx_valid, rx_ready, rx_break, tx_valid, tx_ready, irq;

  int checks = 0;
  int fails  = 0;

  sio_regctl #(.DEPTH(4), .BAUD_HI(BH), .BAUD_LO(BL)) u_sio_regctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .rx_break(rx_break), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic       wr;
    logic [5:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'h04, 8'h00, 8'h08, 4'd1},  // R1 status after reset
    '{1'b0, 6'h00, 8'h00, 8'h00, 4'd1},  // R1 mode byte 1
    '{1'b0, 6'h14, 8'h00, 8'h00, 4'd1},  // R1 interrupt status
    '{1'b1, 6'h00, 8'h41, 8'h00, 4'd2},  // R2 mode 1 write
    '{1'b1, 6'h00, 8'h13, 8'h00, 4'd2},  // R2 mode 2 write
    '{1'b0, 6'h00, 8'h00, 8'h13, 4'd2},  // R2 pointer on second
    '{1'b1, 6'h08, 8'h10, 8'h00, 4'd2},  // R2 pointer reset
    '{1'b0, 6'h00, 8'h00, 8'h41, 4'd2},  // R2 first byte again
    '{1'b1, 6'h04, 8'hFF, 8'h00, 4'd3},  // R3 status write ignored
    '{1'b0, 6'h04, 8'h00, 8'h08, 4'd3},
    '{1'b0, 6'h10, 8'h00, 8'h00, 4'd3},  // R3 aux reads zero
    '{1'b0, 6'h18, 8'h00, BH,    4'd3},  // R3 baud high
    '{1'b0, 6'h1C, 8'h00, BL,    4'd3},  // R3 baud low
    '{1'b0, 6'h3C, 8'h00, 8'h00, 4'd3},  // R3 unlisted offset
    '{1'b1, 6'h08, 8'h05, 8'h00, 4'd4},  // R4 tx on + rx on
    '{1'b0, 6'h04, 8'h00, 8'h0C, 4'd4},
    '{1'b0, 6'h14, 8'h00, 8'h01, 4'd10}, // R10 tx ready bit
    '{1'b1, 6'h08, 8'h0F, 8'h00, 4'd4},  // R4 reserved codes
    '{1'b0, 6'h04, 8'h00, 8'h0C, 4'd4},
    '{1'b1, 6'h08, 8'h08, 8'h00, 4'd4},  // R4 tx off
    '{1'b0, 6'h04, 8'h00, 8'h08, 4'd4}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    bus_rd(a, v);
    check(req, v, exp);
  endtask

  task automatic push_rx(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wr_en = 0; rd_en = 0; addr = '0; wdata = '0;
    rx_valid = 0; rx_data = '0; rx_break = 0; tx_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1", {7'b0, irq}, 8'h00);
    check("R1", {7'b0, tx_valid}, 8'h00);
    check("R1", {7'b0, rx_ready}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_wr(VECS[i].a, VECS[i].d);
      else rd_chk($sformatf("R%0d", VECS[i].req), VECS[i].a, VECS[i].exp);
    end

    // R11 irq from mask
    bus_wr(6'h08, 8'h04);
    bus_wr(6'h14, 8'h01);
    check("R11", {7'b0, irq}, 8'h01);
    bus_wr(6'h14, 8'h02);
    check("R11", {7'b0, irq}, 8'h00);
    bus_wr(6'h14, 8'h00);

    // R7 transmit holding and handshake
    bus_wr(6'h0C, 8'h5A);
    check("R7", {7'b0, tx_valid}, 8'h01);
    check("R7", tx_data, 8'h5A);
    rd_chk("R7", 6'h04, 8'h04);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    check("R7", {7'b0, tx_valid}, 8'h00);
    rd_chk("R7", 6'h04, 8'h0C);
    bus_wr(6'h08, 8'h08);
    bus_wr(6'h0C, 8'h33);
    check("R7", {7'b0, tx_valid}, 8'h00);
    rd_chk("R7", 6'h04, 8'h00);
    bus_wr(6'h08, 8'h04);
    check("R7", {7'b0, tx_valid}, 8'h01);
    check("R7", tx_data, 8'h33);

    // R6 transmitter reset and no-effect code
    bus_wr(6'h08, 8'h30);
    check("R6", {7'b0, tx_valid}, 8'h00);
    rd_chk("R6", 6'h04, 8'h08);
    bus_wr(6'h08, 8'h40);
    rd_chk("R6", 6'h04, 8'h08);

    // R8 queue order and full, R10 source select
    push_rx(8'h11); push_rx(8'h22); push_rx(8'h33); push_rx(8'h44);
    check("R8", {7'b0, rx_ready}, 8'h00);
    rd_chk("R8", 6'h04, 8'h0B);
    rd_chk("R10", 6'h14, 8'h02);
    rd_chk("R8", 6'h0C, 8'h11);
    rd_chk("R8", 6'h04, 8'h09);
    rd_chk("R10", 6'h14, 8'h00);
    bus_wr(6'h08, 8'h10);
    bus_wr(6'h00, 8'h00);
    rd_chk("R10", 6'h14, 8'h02);
    rd_chk("R8", 6'h0C, 8'h22);
    rd_chk("R8", 6'h0C, 8'h33);
    rd_chk("R8", 6'h0C, 8'h44);
    rd_chk("R8", 6'h0C, 8'h00);
    rd_chk("R8", 6'h04, 8'h08);

    // R9 break on full queue
    push_rx(8'h11); push_rx(8'h12); push_rx(8'h13); push_rx(8'h14);
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd_chk("R9", 6'h14, 8'h06);
    rd_chk("R9", 6'h0C, 8'h11);
    rd_chk("R9", 6'h0C, 8'h12);
    rd_chk("R9", 6'h0C, 8'h13);
    rd_chk("R9", 6'h0C, 8'h00);
    rd_chk("R9", 6'h04, 8'h08);
    bus_wr(6'h08, 8'h50);
    rd_chk("R6", 6'h14, 8'h00);

    // R5 receiver reset
    push_rx(8'hAA); push_rx(8'hBB);
    rd_chk("R5", 6'h04, 8'h09);
    bus_wr(6'h08, 8'h20);
    rd_chk("R5", 6'h04, 8'h08);
    check("R5", {7'b0, rx_ready}, 8'h00);
    push_rx(8'hCC);
    rd_chk("R5", 6'h0C, 8'h00);

    // R4 combined fields in one write
    bus_wr(6'h08, 8'h25);
    rd_chk("R4", 6'h04, 8'h0C);
    check("R4", {7'b0, rx_ready}, 8'h01);

    // R1 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1", 6'h04, 8'h08);
    rd_chk("R1", 6'h00, 8'h00);
    check("R1", {7'b0, irq}, 8'h00);
    check("R1", {7'b0, rx_ready}, 8'h00);
    check("R1", {7'b0, tx_valid}, 8'h00);

    finish_run();
  end

endmodule